// File: doc/BRIEF.md
# Quad DAC Serial Control Logic

This block is the digital front end of a four-channel voltage-output converter. A host sends 24-bit command frames over a three-wire serial port made of an active-low select, a serial clock and a data line. The block decodes each frame and keeps two register stages per channel. The first is a code register that the host writes. The second is a DAC latch, and only the latch drives the converter code. Latches change on a software load command or on a falling edge of the hardware load pin. That pin updates every channel in the same cycle, so all outputs can move together.

An asynchronous clear pin zeroes both register stages of all channels. Power-on reset does the same and also restores the mode bits. The block also holds the mode state that the analog side needs: a two-bit power-down selection per channel, a reference level selection, and a reference enable. A ready output marks the moment a complete frame has been taken in, for use in daisy chains.

The serial pins are sampled in the system clock domain through two-flop synchronisers. The receiver is a four-state machine: RX_IDLE waits for select low and moves to RX_SHIFT. RX_SHIFT counts falling serial-clock edges; on the 24th it moves to RX_FULL, and if select rises first it returns to RX_IDLE. RX_FULL asserts ready and emits the frame when select rises (back to RX_IDLE); a further falling edge moves it to RX_OVER. RX_OVER discards the frame and returns to RX_IDLE when select rises.

Top module: `quad_dac_ctrl`

## Requirements
- R1: A frame is 24 bits, MSB first, sampled on falling `sclk` edges while `cs_n` is low. Bits 23:20 hold the command, 19:16 the address and 15:0 the data. The frame is decoded when `cs_n` rises.
- R2: Command 0x1 (write) updates only the addressed code registers; `dac_codes` does not change.
- R3: Command 0x2 (load) copies the addressed code registers into their latches. Command 0x3 writes the code and updates the latch of the addressed channels in one step.
- R4: Addresses 0 to 3 select one channel and 0xF selects all of them; any other address has no effect.
- R5: A falling edge on `ldac_n` copies every code register into its latch in the same cycle.
- R6: While `clr_n` is low, all code registers and latches are zero, whatever load arrives at the same time; `pd_modes`, `ref_en` and `ref_sel` keep their values.
- R7: After reset, `dac_codes` is zero, every power-down field is 0, `ref_en` is 0, `ref_sel` is 0 and `rdy` is 0.
- R8: Command 0x4 sets the power-down field of the addressed channels to data[1:0]: 0 normal, 1 one kilohm, 2 one hundred kilohm, 3 high impedance. Channel i uses `pd_modes[2i+1:2i]`.
- R9: Command 0x7 sets `ref_en` from data[2] and `ref_sel` from data[1:0], where 0 is 2.048 V, 1 is 2.500 V and 2 is 4.096 V. A selection of 3 makes the whole command have no effect.
- R10: A frame with anything other than exactly 24 falling edges is discarded. Commands other than 0x1, 0x2, 0x3, 0x4 and 0x7 have no effect.
- R11: `rdy` is high from the 24th falling edge until `cs_n` rises. It stays low during shorter frames and drops when a 25th edge arrives.
- R12: Codes are left-justified: a channel's code is data[15:16-RES]. Channel i drives `dac_codes[RES*i +: RES]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of codes and latches |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sdi | input | 1 | Serial data in |
| ldac_n | input | 1 | Hardware load, acts on its falling edge |
| dac_codes | output | NCH*RES | Latched converter codes, channel i at RES*i |
| pd_modes | output | 2*NCH | Power-down selection, two bits per channel |
| ref_sel | output | 2 | Reference level selection |
| ref_en | output | 1 | Internal reference enable |
| rdy | output | 1 | Full frame received |

## Verification
A random stream of frames mixes write, load, write-and-load, power-down, reference and unknown commands. Addresses are drawn from single channels, the broadcast value and unused values, so the stream separates per-channel selection from broadcast and from ignored addresses. Hardware load pulses fall between frames at random points, which tells a latch that follows its code register apart from one that waits for a load. Directed cases cover 23-bit and 25-bit frames, clear held across a load, the reserved reference value, and reset. These show whether the frame-length filter, the priority of clear and the reset values are kept.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    localparam int FRAME_BITS = 24;
    localparam logic [3:0] ADDR_ALL = 4'hF;

    localparam logic [3:0] CMD_WRITE  = 4'h1;
    localparam logic [3:0] CMD_LOAD   = 4'h2;
    localparam logic [3:0] CMD_WRLOAD = 4'h3;
    localparam logic [3:0] CMD_POWER  = 4'h4;
    localparam logic [3:0] CMD_REF    = 4'h7;

    localparam logic [1:0] REF_RESERVED = 2'd3;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [3:0]  addr;
        logic [15:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_FULL,
        RX_OVER
    } rx_state_e;

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            dout <= INIT;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/dac_spi_rx.sv
module dac_spi_rx
    import quad_dac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sclk_s,
    input  logic   cs_n_s,
    input  logic   sdi_s,
    output logic   frame_valid,
    output frame_t frame,
    output logic   rdy
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    rx_state_e state, state_nx;
    logic              sclk_d;
    logic              fall;
    logic [CW-1:0]     cnt;
    logic [FRAME_BITS-1:0] shreg;

    assign fall = sclk_d & ~sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (!cs_n_s) state_nx = RX_SHIFT;
            RX_SHIFT: begin
                if (cs_n_s)                   state_nx = RX_IDLE;
                else if (fall && cnt == LAST) state_nx = RX_FULL;
            end
            RX_FULL: begin
                if (cs_n_s)    state_nx = RX_IDLE;
                else if (fall) state_nx = RX_OVER;
            end
            RX_OVER:  if (cs_n_s) state_nx = RX_IDLE;
        endcase
    end

    // datapath: edge history, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            cnt    <= '0;
            shreg  <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (state == RX_IDLE) begin
                cnt <= '0;
            end else if (state == RX_SHIFT && !cs_n_s && fall) begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
            end
        end
    end

    // outputs
    always_comb begin
        rdy         = (state == RX_FULL);
        frame_valid = (state == RX_FULL) && cs_n_s;
        frame       = frame_t'(shreg);
    end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wipe_n,
    input  logic           wr_en,
    input  logic           ld_en,
    input  logic [RES-1:0] wr_code,
    input  logic           pd_en,
    input  logic [1:0]     pd_in,
    output logic [RES-1:0] latch_q,
    output logic [1:0]     pd_q
);
    logic [RES-1:0] code_q;

    // code register and DAC latch: cleared by reset or clear
    always_ff @(posedge clk or negedge wipe_n) begin
        if (!wipe_n) begin
            code_q  <= '0;
            latch_q <= '0;
        end else begin
            if (wr_en) code_q <= wr_code;
            if (ld_en) latch_q <= wr_en ? wr_code : code_q;
        end
    end

    // power-down mode: only reset restores it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pd_q <= 2'd0;
        else if (pd_en) pd_q <= pd_in;
    end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
    import quad_dac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int RES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             ldac_n,
    output logic [NCH*RES-1:0] dac_codes,
    output logic [2*NCH-1:0] pd_modes,
    output logic [1:0]       ref_sel,
    output logic             ref_en,
    output logic             rdy
);
    localparam int DMSB = 15;

    logic       sclk_s, cs_n_s, sdi_s, ldac_s, ldac_d;
    logic       frame_valid;
    frame_t     fr;
    logic       hw_ld;
    logic       wipe_n;
    logic       is_wr, is_ld, is_pd, is_ref;
    logic [NCH-1:0] sel, wr_en, ld_en, pd_en;
    logic       ld_any;

    dac_sync #(.W(4), .INIT(4'b1011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk, cs_n, sdi, ldac_n}),
        .dout ({sclk_s, cs_n_s, sdi_s, ldac_s})
    );

    dac_spi_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .cs_n_s     (cs_n_s),
        .sdi_s      (sdi_s),
        .frame_valid(frame_valid),
        .frame      (fr),
        .rdy        (rdy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldac_d <= 1'b1;
        else        ldac_d <= ldac_s;
    end

    assign hw_ld  = ldac_d & ~ldac_s;
    assign wipe_n = rst_n & clr_n;

    always_comb begin
        is_wr  = frame_valid && (fr.cmd == CMD_WRITE || fr.cmd == CMD_WRLOAD);
        is_ld  = frame_valid && (fr.cmd == CMD_LOAD  || fr.cmd == CMD_WRLOAD);
        is_pd  = frame_valid && (fr.cmd == CMD_POWER);
        is_ref = frame_valid && (fr.cmd == CMD_REF) && (fr.data[1:0] != REF_RESERVED);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign sel[i]   = (fr.addr == 4'(i)) || (fr.addr == ADDR_ALL);
        assign wr_en[i] = is_wr && sel[i];
        assign ld_en[i] = hw_ld || (is_ld && sel[i]);
        assign pd_en[i] = is_pd && sel[i];

        dac_chan #(.RES(RES)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wipe_n (wipe_n),
            .wr_en  (wr_en[i]),
            .ld_en  (ld_en[i]),
            .wr_code(fr.data[DMSB -: RES]),
            .pd_en  (pd_en[i]),
            .pd_in  (fr.data[1:0]),
            .latch_q(dac_codes[RES*i +: RES]),
            .pd_q   (pd_modes[2*i +: 2])
        );
    end

    assign ld_any = |ld_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_en  <= 1'b0;
            ref_sel <= 2'd0;
        end else if (is_ref) begin
            ref_en  <= fr.data[2];
            ref_sel <= fr.data[1:0];
        end
    end
endmodule

// File: rtl/quad_dac_chk.sv
module quad_dac_chk #(
    parameter int NCH = 4,
    parameter int RES = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic [NCH*RES-1:0] dac_codes,
    input logic [2*NCH-1:0] pd_modes,
    input logic [1:0]       ref_sel,
    input logic             ref_en,
    input logic             frame_valid,
    input logic             ld_any
);
    // R6: clear holds both stages at zero
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> dac_codes == '0);

    // R2 / R5: a latch only moves after a load event
    a_r2_latch_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_codes) && clr_n && $past(clr_n)) |-> $past(ld_any));

    // R8: power-down bits only move after a decoded frame
    a_r8_pd_by_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pd_modes) |-> $past(frame_valid));

    // R9: reference bits only move after a decoded frame, never to the reserved code
    a_r9_ref_by_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ref_en, ref_sel}) |-> ($past(frame_valid) && ref_sel != 2'd3));

    // R7: reset values
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r7_reset_vals: assert (dac_codes == '0 && pd_modes == '0 && !ref_en && ref_sel == 2'd0);
        end
    end
endmodule

bind quad_dac_ctrl quad_dac_chk #(.NCH(NCH), .RES(RES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .dac_codes  (dac_codes),
    .pd_modes   (pd_modes),
    .ref_sel    (ref_sel),
    .ref_en     (ref_en),
    .frame_valid(frame_valid),
    .ld_any     (ld_any)
);

// File: tb/tb_quad_dac_ctrl.sv
module tb_quad_dac_ctrl;
    localparam int NCH  = 4;
    localparam int RES  = 12;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic sdi = 1'b0;
    logic ldac_n = 1'b1;
    logic [NCH*RES-1:0] dac_codes;
    logic [2*NCH-1:0]   pd_modes;
    logic [1:0]         ref_sel;
    logic               ref_en;
    logic               rdy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [RES-1:0] m_code [NCH];
    logic [RES-1:0] m_lat  [NCH];
    logic [1:0]     m_pd   [NCH];
    logic           m_ren;
    logic [1:0]     m_rsel;

    always #2 clk = ~clk;

    quad_dac_ctrl #(.NCH(NCH), .RES(RES)) dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .ldac_n(ldac_n), .dac_codes(dac_codes), .pd_modes(pd_modes),
        .ref_sel(ref_sel), .ref_en(ref_en), .rdy(rdy)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH*RES-1:0] exp_codes();
        logic [NCH*RES-1:0] v;
        for (int i = 0; i < NCH; i++) v[RES*i +: RES] = m_lat[i];
        return v;
    endfunction

    function automatic logic [2*NCH-1:0] exp_pd();
        logic [2*NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[2*i +: 2] = m_pd[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_code[i] = '0; m_lat[i] = '0; m_pd[i] = 2'd0;
        end
        m_ren = 1'b0; m_rsel = 2'd0;
    endtask

    // model of one decoded frame (R2, R3, R4, R8, R9, R10, R12)
    task automatic model_frame(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
        for (int i = 0; i < NCH; i++) begin
            if (addr == 4'(i) || addr == 4'hF) begin
                case (cmd)
                    4'h1: m_code[i] = data[15 -: RES];
                    4'h2: m_lat[i] = m_code[i];
                    4'h3: begin m_code[i] = data[15 -: RES]; m_lat[i] = m_code[i]; end
                    4'h4: m_pd[i] = data[1:0];
                    default: ;
                endcase
            end
        end
        if (cmd == 4'h7 && data[1:0] != 2'd3) begin
            m_ren = data[2]; m_rsel = data[1:0];
        end
    endtask

    task automatic model_hwload();
        for (int i = 0; i < NCH; i++) m_lat[i] = m_code[i];
    endtask

    task automatic check_all(input string tag);
        check({tag, " codes"}, 64'(dac_codes), 64'(exp_codes()));
        check({tag, " pd"}, 64'(pd_modes), 64'(exp_pd()));
        check({tag, " ref"}, 64'({ref_en, ref_sel}), 64'({m_ren, m_rsel}));
    endtask

    // R1, R11: shift nbits, check rdy before select rises
    task automatic send(input logic [23:0] w, input int nbits);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 24) ? w[23-i] : 1'b0;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
        end
        wait_clk(HALF);
        check("R11 rdy at frame end", 64'(rdy), 64'(nbits == 24));
        cs_n = 1'b1;
        wait_clk(8);
        check("R11 rdy after select", 64'(rdy), 64'd0);
        if (nbits == 24) model_frame(w[23:20], w[19:16], w[15:0]);
    endtask

    task automatic hw_pulse();
        ldac_n = 1'b0;
        wait_clk(3);
        ldac_n = 1'b1;
        wait_clk(5);
        model_hwload();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] cmds [7] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h7, 4'h0, 4'h9};
        void'($urandom(32'd1234));
        model_reset();
        wait_clk(4);
        check_all("R7 reset");
        check("R7 rdy reset", 64'(rdy), 64'd0);
        rst_n = 1'b1;
        wait_clk(4);

        // R2: write leaves latch alone; R12 left justified
        send({4'h1, 4'h0, 16'hABC5}, 24);
        check_all("R2 write only");
        check("R2 latch unchanged", 64'(dac_codes), 64'd0);
        // R3: load moves it
        send({4'h2, 4'h0, 16'h0000}, 24);
        check_all("R3 load");
        check("R12 justify", 64'(dac_codes[RES-1:0]), 64'h0ABC);
        // R3: write and load, channel 2
        send({4'h3, 4'h2, 16'h1234}, 24);
        check_all("R3 write and load");
        // R4: broadcast and unused address
        send({4'h1, 4'hF, 16'h5550}, 24);
        send({4'h3, 4'h6, 16'hFFF0}, 24);
        check_all("R4 unused address");
        // R5: hardware load
        hw_pulse();
        check_all("R5 hw load");
        // R10: short and long frames
        send({4'h3, 4'hF, 16'h7770}, 23);
        check_all("R10 short frame");
        send({4'h3, 4'hF, 16'h7770}, 25);
        check_all("R10 long frame");
        // R8, R9
        send({4'h4, 4'h1, 16'h0003}, 24);
        send({4'h7, 4'h0, 16'h0006}, 24);
        check_all("R8 R9 modes");
        send({4'h7, 4'h0, 16'h0003}, 24);
        check_all("R9 reserved");

        // random stream
        for (int n = 0; n < 60; n++) begin
            logic [3:0] c, a;
            logic [15:0] d;
            c = cmds[$urandom_range(0, 6)];
            a = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom_range(0, 7));
            d = 16'($urandom);
            send({c, a, d}, 24);
            if ($urandom_range(0, 4) == 0) hw_pulse();
            check_all("R1 R3 R4 random");
        end

        // R6: clear across a load, modes kept
        send({4'h1, 4'hF, 16'hDEF0}, 24);
        clr_n = 1'b0;
        ldac_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < NCH; i++) begin m_code[i] = '0; m_lat[i] = '0; end
        check_all("R6 clear beats load");
        ldac_n = 1'b1;
        clr_n = 1'b1;
        wait_clk(6);
        send({4'h2, 4'hF, 16'h0000}, 24);
        check_all("R6 code regs cleared");

        // R7: reset again
        rst_n = 1'b0;
        model_reset();
        wait_clk(3);
        check_all("R7 second reset");
        rst_n = 1'b1;
        wait_clk(3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule